// File: doc/BRIEF.md
# Scan-Reusing Upset-Tolerant Register

This block is a W-bit storage register. Each bit is made of two master/slave pairs. The system pair is a low-phase latch and a high-phase latch, and the high-phase latch drives `q`. The redundant pair has the same two latches. In functional operation the redundant pair shadows the system pair, so every stored bit exists four times. The same redundant latches form the register's scan chain in test mode. No extra storage is spent on detection.

The `err` output is high whenever any low-phase redundant latch differs from its system twin, or any high-phase redundant latch differs from its system twin. The flag stays high for as long as the disagreement lasts. It therefore drops only when a new write, a recovery, or a second upset restores agreement.

A recovery point arrives in two ways: on a request, or every `REC_CYCLES` clock cycles from an internal timer. At a recovery point all four latches of every bit are rewritten with the two-of-three vote of the system high-phase latch and both redundant latches. The tests use per-latch upset strobes to flip single latches on purpose.

Top module: `seu_scan_reg`

## Requirements
- R1: While `rst_n` is low, every latch and the recovery timer are cleared. After reset, `q`=0, `err`=0 and `scan_out`=0.
- R2: With no scan control high, `wr_en` loads `d[i]` into all four latches of bit i at the clock edge. After that edge `q` equals `d` and `err` is 0.
- R3: In a cycle with no write, scan control, recovery point or upset strobe, `q` and `err` keep their values.
- R4: An upset strobe (`hit_sys_lo`, `hit_sys_hi`, `hit_red_lo`, `hit_red_hi`, bit i) applied in an otherwise idle cycle inverts that one latch at the edge. If the bit was consistent, `err` is 1 after that edge. `q[i]` changes only for `hit_sys_hi`.
- R5: `err` is the OR over all bits of (system low ≠ redundant low) or (system high ≠ redundant high). A second strobe on the same latch therefore clears it again.
- R6: `rec_req` creates a recovery point. Every bit's four latches take the majority of its system-high, redundant-low and redundant-high values. After the edge `err` is 0, and a single upset is undone.
- R7: The timer counts clock edges from 0. When it holds `REC_CYCLES`-1, that cycle is a recovery point. The timer returns to 0 on that cycle and on any cycle with `rec_req`.
- R8: Priority below the scan controls is: write, then recovery point, then upset strobes. A losing action has no effect in that cycle.
- R9: `shift_a` loads redundant-low of bit 0 from `scan_in`, and redundant-low of bit i from redundant-high of bit i-1. `shift_b` copies redundant-low into redundant-high in every bit. `scan_out` is redundant-high of bit W-1.
- R10: `upd_xfer` copies redundant-high into system-high (and so into `q`) in every bit.
- R11: `cap_xfer` copies system-low into redundant-low in every bit.
- R12: A scan control outranks write, recovery and strobes. Among the scan controls the order is `shift_a`, `shift_b`, `upd_xfer`, `cap_xfer`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Functional write enable |
| d | input | W | Write data |
| shift_a | input | 1 | Scan shift into redundant-low latches |
| shift_b | input | 1 | Scan shift into redundant-high latches |
| upd_xfer | input | 1 | Copy redundant-high into system-high |
| cap_xfer | input | 1 | Copy system-low into redundant-low |
| scan_in | input | 1 | Scan chain input |
| rec_req | input | 1 | Immediate recovery point request |
| hit_sys_lo | input | W | Upset strobe, system low-phase latch |
| hit_sys_hi | input | W | Upset strobe, system high-phase latch |
| hit_red_lo | input | W | Upset strobe, redundant low-phase latch |
| hit_red_hi | input | W | Upset strobe, redundant high-phase latch |
| q | output | W | Register output |
| err | output | 1 | Held disagreement flag |
| scan_out | output | 1 | Scan chain output |

## Verification
An upset strobe can land in the same cycle as a recovery point, whether from the timer or from `rec_req`. The recovery must win, and the strobe must leave no trace.

The bench waits until its own timer model reports the last count, then fires a strobe on a system-high latch in exactly that cycle. After the edge it expects `err` low and `q` equal to the value written earlier. A second case stacks a write, a request and strobes in one cycle and expects the written data with a clean flag. Random traffic repeats these collisions, and a cycle-exact bench model judges each one.

// File: rtl/seu_scan_pkg.sv
package seu_scan_pkg;

    // One stored bit: four latches, system pair first, redundant pair second.
    typedef struct packed {
        logic sys_lo;
        logic sys_hi;
        logic red_lo;
        logic red_hi;
    } cell_t;

    // Action taken by every cell in one cycle, already resolved by priority.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SHIFT_A,
        OP_SHIFT_B,
        OP_UPDATE,
        OP_CAPTURE,
        OP_WRITE,
        OP_RECOVER
    } op_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic cell_t fill_cell(input logic v);
        cell_t c;
        c.sys_lo = v;
        c.sys_hi = v;
        c.red_lo = v;
        c.red_hi = v;
        return c;
    endfunction

endpackage

// File: rtl/seu_scan_opsel.sv
module seu_scan_opsel
    import seu_scan_pkg::*;
(
    input  logic shift_a,
    input  logic shift_b,
    input  logic upd_xfer,
    input  logic cap_xfer,
    input  logic wr_en,
    input  logic rec_point,
    output op_e  op
);

    // Scan controls first, then write, then recovery; upsets only when idle.
    always_comb begin
        if (shift_a)        op = OP_SHIFT_A;
        else if (shift_b)   op = OP_SHIFT_B;
        else if (upd_xfer)  op = OP_UPDATE;
        else if (cap_xfer)  op = OP_CAPTURE;
        else if (wr_en)     op = OP_WRITE;
        else if (rec_point) op = OP_RECOVER;
        else                op = OP_IDLE;
    end

endmodule

// File: rtl/seu_scan_timer.sv
module seu_scan_timer #(
    parameter int REC_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic hit
);

    localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign hit = (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (hit || req) tmr_d.cnt = '0;
        else            tmr_d.cnt = tmr_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/seu_scan_cell.sv
module seu_scan_cell
    import seu_scan_pkg::*;
(
    input  op_e        op,
    input  logic       d,
    input  logic       chain_in,
    input  cell_t      cur,
    input  logic [3:0] upset,
    output cell_t      nxt,
    output logic       mism
);

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_SHIFT_A: nxt.red_lo = chain_in;
            OP_SHIFT_B: nxt.red_hi = cur.red_lo;
            OP_UPDATE:  nxt.sys_hi = cur.red_hi;
            OP_CAPTURE: nxt.red_lo = cur.sys_lo;
            OP_WRITE:   nxt = fill_cell(d);
            OP_RECOVER: nxt = fill_cell(vote3(cur.sys_hi, cur.red_lo, cur.red_hi));
            default:    nxt = cell_t'(cur ^ upset);
        endcase
    end

    assign mism = (cur.sys_lo ^ cur.red_lo) | (cur.sys_hi ^ cur.red_hi);

endmodule

// File: rtl/seu_scan_reg.sv
module seu_scan_reg
    import seu_scan_pkg::*;
#(
    parameter int W          = 8,
    parameter int REC_CYCLES = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] d,
    input  logic         shift_a,
    input  logic         shift_b,
    input  logic         upd_xfer,
    input  logic         cap_xfer,
    input  logic         scan_in,
    input  logic         rec_req,
    input  logic [W-1:0] hit_sys_lo,
    input  logic [W-1:0] hit_sys_hi,
    input  logic [W-1:0] hit_red_lo,
    input  logic [W-1:0] hit_red_hi,
    output logic [W-1:0] q,
    output logic         err,
    output logic         scan_out
);

    typedef struct packed {
        cell_t [W-1:0] cells;
    } st_t;

    st_t           st_d, st_q;
    cell_t [W-1:0] nxt_cells;
    logic  [W-1:0] mism_v;
    logic  [W-1:0] chain;
    logic  [W-1:0] red_lo_v;
    logic  [W-1:0] red_hi_v;
    logic          rec_hit;
    op_e           op;

    seu_scan_timer #(.REC_CYCLES(REC_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rec_req),
        .hit   (rec_hit)
    );

    seu_scan_opsel opsel_i (
        .shift_a   (shift_a),
        .shift_b   (shift_b),
        .upd_xfer  (upd_xfer),
        .cap_xfer  (cap_xfer),
        .wr_en     (wr_en),
        .rec_point (rec_hit | rec_req),
        .op        (op)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_head
            assign chain[i] = scan_in;
        end else begin : g_link
            assign chain[i] = st_q.cells[i-1].red_hi;
        end

        seu_scan_cell cell_i (
            .op       (op),
            .d        (d[i]),
            .chain_in (chain[i]),
            .cur      (st_q.cells[i]),
            .upset    ({hit_sys_lo[i], hit_sys_hi[i], hit_red_lo[i], hit_red_hi[i]}),
            .nxt      (nxt_cells[i]),
            .mism     (mism_v[i])
        );

        assign q[i]        = st_q.cells[i].sys_hi;
        assign red_lo_v[i] = st_q.cells[i].red_lo;
        assign red_hi_v[i] = st_q.cells[i].red_hi;
    end

    always_comb begin
        st_d       = st_q;
        st_d.cells = nxt_cells;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err      = |mism_v;
    assign scan_out = red_hi_v[W-1];

endmodule

// File: rtl/seu_scan_chk.sv
module seu_scan_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] d,
    input logic         shift_a,
    input logic         shift_b,
    input logic         upd_xfer,
    input logic         cap_xfer,
    input logic         rec_req,
    input logic [W-1:0] hit_sys_lo,
    input logic [W-1:0] hit_sys_hi,
    input logic [W-1:0] hit_red_lo,
    input logic [W-1:0] hit_red_hi,
    input logic [W-1:0] q,
    input logic         err,
    input logic         scan_out,
    input logic         rec_hit,
    input logic [W-1:0] red_lo_v,
    input logic [W-1:0] red_hi_v
);

    logic scan_any;
    logic quiet;
    int   n_hits;

    assign scan_any = shift_a | shift_b | upd_xfer | cap_xfer;
    assign n_hits   = $countones({hit_sys_lo, hit_sys_hi, hit_red_lo, hit_red_hi});
    assign quiet    = !scan_any && !wr_en && !rec_req && !rec_hit;

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !scan_any) |=> (q == $past(d) && !err));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && n_hits == 0) |=> ($stable(q) && $stable(err)));

    assert_single_upset_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !err && n_hits == 1) |=> err);

    assert_request_cleans_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_req && !wr_en && !scan_any) |=> !err);

    assert_timer_cleans_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_hit && !wr_en && !scan_any) |=> !err);

    assert_chain_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_b && !shift_a) |=> (scan_out == $past(red_lo_v[W-1])));

    assert_update_copies_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_xfer && !shift_a && !shift_b) |=> (q == $past(red_hi_v)));

endmodule

bind seu_scan_reg seu_scan_chk #(.W(W)) chk_i (.*);

// File: tb/seu_scan_reg_tb_top.sv
module seu_scan_reg_tb_top;

    localparam int W   = 8;
    localparam int REC = 24;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en, shift_a, shift_b, upd_xfer, cap_xfer, scan_in, rec_req;
    logic [W-1:0] d, hit_sys_lo, hit_sys_hi, hit_red_lo, hit_red_hi;
    logic [W-1:0] q;
    logic         err, scan_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [W-1:0] m_slo, m_shi, m_rlo, m_rhi;
    int           m_cnt;

    always #4 clk = ~clk;

    seu_scan_reg #(.W(W), .REC_CYCLES(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .d(d),
        .shift_a(shift_a), .shift_b(shift_b), .upd_xfer(upd_xfer), .cap_xfer(cap_xfer),
        .scan_in(scan_in), .rec_req(rec_req),
        .hit_sys_lo(hit_sys_lo), .hit_sys_hi(hit_sys_hi),
        .hit_red_lo(hit_red_lo), .hit_red_hi(hit_red_hi),
        .q(q), .err(err), .scan_out(scan_out)
    );

    task automatic clear_in();
        wr_en = 0; shift_a = 0; shift_b = 0; upd_xfer = 0; cap_xfer = 0;
        scan_in = 0; rec_req = 0; d = '0;
        hit_sys_lo = '0; hit_sys_hi = '0; hit_red_lo = '0; hit_red_hi = '0;
    endtask

    // Requirement-level model of one clock edge.
    task automatic model_edge();
        logic [W-1:0] o_slo = m_slo;
        logic [W-1:0] o_shi = m_shi;
        logic [W-1:0] o_rlo = m_rlo;
        logic [W-1:0] o_rhi = m_rhi;
        logic [W-1:0] v;
        bit hit = (m_cnt == REC - 1);
        if (!rst_n) begin
            m_slo = '0; m_shi = '0; m_rlo = '0; m_rhi = '0; m_cnt = 0;
            return;
        end
        if (shift_a) begin
            for (int i = 0; i < W; i++) m_rlo[i] = (i == 0) ? scan_in : o_rhi[i-1];
        end else if (shift_b) begin
            m_rhi = o_rlo;
        end else if (upd_xfer) begin
            m_shi = o_rhi;
        end else if (cap_xfer) begin
            m_rlo = o_slo;
        end else if (wr_en) begin
            m_slo = d; m_shi = d; m_rlo = d; m_rhi = d;
        end else if (hit || rec_req) begin
            v = (o_shi & o_rlo) | (o_shi & o_rhi) | (o_rlo & o_rhi);
            m_slo = v; m_shi = v; m_rlo = v; m_rhi = v;
        end else begin
            m_slo = o_slo ^ hit_sys_lo;
            m_shi = o_shi ^ hit_sys_hi;
            m_rlo = o_rlo ^ hit_red_lo;
            m_rhi = o_rhi ^ hit_red_hi;
        end
        m_cnt = (hit || rec_req) ? 0 : m_cnt + 1;
    endtask

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_err();
        return |((m_slo ^ m_rlo) | (m_shi ^ m_rhi));
    endfunction

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " q"}, q, m_shi);
        check({tag, " err"}, {{(W-1){1'b0}}, err}, {{(W-1){1'b0}}, exp_err()});
        check({tag, " scan_out"}, {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, m_rhi[W-1]});
        clear_in();
    endtask

    task automatic strike(int kind, int b);
        case (kind)
            0: hit_sys_lo[b] = 1'b1;
            1: hit_sys_hi[b] = 1'b1;
            2: hit_red_lo[b] = 1'b1;
            default: hit_red_hi[b] = 1'b1;
        endcase
    endtask

    initial begin
        logic [W-1:0] val;
        logic [W-1:0] pat;
        void'($urandom(32'h5EED_0042));
        clear_in();
        rst_n = 0;
        m_slo = '0; m_shi = '0; m_rlo = '0; m_rhi = '0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: state after reset
        check("R1 q", q, '0);
        check("R1 err", {{(W-1){1'b0}}, err}, '0);
        check("R1 scan_out", {{(W-1){1'b0}}, scan_out}, '0);

        // R2, R4, R5, R6: one latch kind per trial
        for (int k = 0; k < 4; k++) begin
            int b = int'($urandom % W);
            val = W'($urandom);
            wr_en = 1; d = val; step("R2 write");
            strike(k, b); step("R4 single upset");
            strike(k, b); step("R5 repeat upset");
            strike(k, b); step("R4 upset again");
            rec_req = 1; step("R6 request");
            check("R6 restored q", q, val);
            check("R6 err clear", {{(W-1){1'b0}}, err}, '0);
        end

        // R7: timer recovery without a request
        val = 8'h3C;
        wr_en = 1; d = val; step("R2 write");
        strike(2, 5); step("R4 upset");
        for (int n = 0; n < REC; n++) step("R7 timer wait");
        check("R7 restored q", q, val);
        check("R7 err clear", {{(W-1){1'b0}}, err}, '0);

        // R8: write, request and strobes in one cycle
        wr_en = 1; d = 8'h0F; step("R2 write");
        wr_en = 1; d = 8'hA6; rec_req = 1; hit_sys_hi = 8'h81; hit_red_lo = 8'h10;
        step("R8 stacked");
        check("R8 write wins", q, 8'hA6);
        check("R8 err clear", {{(W-1){1'b0}}, err}, '0);

        // R8: strobe landing on the timer recovery point
        while (m_cnt != REC - 1) step("R7 align");
        strike(1, 3); step("R8 strobe at timer");
        check("R8 strobe ignored q", q, 8'hA6);
        check("R8 strobe ignored err", {{(W-1){1'b0}}, err}, '0);

        // R9, R10, R11: scan load, update, capture, unload
        pat = 8'hD2;
        for (int i = W - 1; i >= 0; i--) begin
            scan_in = pat[i]; shift_a = 1; step("R9 shift a");
            shift_b = 1; step("R9 shift b");
        end
        upd_xfer = 1; step("R10 update");
        check("R10 q from chain", q, pat);
        cap_xfer = 1; step("R11 capture");
        for (int i = 0; i < W; i++) begin
            shift_a = 1; step("R9 unload a");
            shift_b = 1; step("R9 unload b");
        end

        // R12: scan control beats write, request and strobes
        val = q;
        shift_a = 1; wr_en = 1; d = ~val; rec_req = 1; hit_sys_hi = 8'hFF;
        step("R12 scan priority");
        check("R12 q untouched", q, val);
        upd_xfer = 1; cap_xfer = 1; step("R12 update over capture");

        // Random traffic mixed with the directed cases above
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 16);
            case (r)
                0: begin shift_a = 1; scan_in = 1'($urandom); end
                1: shift_b = 1;
                2: upd_xfer = 1;
                3: cap_xfer = 1;
                4, 5, 6: begin wr_en = 1; d = W'($urandom); end
                7: rec_req = 1;
                default: ;
            endcase
            if ($urandom % 3 == 0) strike(int'($urandom % 4), int'($urandom % W));
            if ($urandom % 29 == 0) rec_req = 1;
            step("random R4 R6 R8 R12");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule